// File: doc/BRIEF.md
# Time Alarm Matcher with Wildcards

This block decides, at every seconds update of a real-time clock, whether the alarm time has been reached. It compares three alarm bytes (seconds, minutes, hours) against the three current-time bytes. It emits a single-cycle match pulse that the surrounding clock logic uses to set its alarm flag. Flag storage and interrupt gating belong to that surrounding logic.

Any alarm byte whose two top bits are both set is a wildcard that accepts every current value. With wildcards the alarm can repeat every second, every minute or every hour. Each byte is decoded as BCD or as plain binary, following the clock's data mode. In 12-hour mode each hour byte carries its own PM flag in bit 7 and is normalised to a 0..23 hour before the comparison.

The update strobe is asserted for one cycle once the current-time bytes already hold the new time, so the comparison uses the post-update time. No match is reported while the time is frozen for setting or while the dividers are held in reset.

Top module: `alarm_matcher`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `alarm_hit` is 0.
- R2: In BCD, 24-hour mode, when all three alarm bytes equal the three current bytes, a strobe produces `alarm_hit` = 1.
- R3: If any non-wildcard field decodes to a different value than its current field, a strobe produces no pulse.
- R4: An alarm byte with bits [7:6] = 2'b11 matches any current value. With all three bytes in wildcard form, every strobe produces a pulse.
- R5: In BCD mode (`bin_mode` = 0), a byte is worth high nibble × 10 plus low nibble. Alarm seconds 0x0A therefore matches current seconds 0x10.
- R6: In binary mode (`bin_mode` = 1), a byte is worth its plain value. Alarm 0x0A then does not match current 0x10.
- R7: In 12-hour mode (`hr24_mode` = 0), an hour byte is normalised to ((value of bits [6:0]) mod 12) + 12 when bit 7 is set. Alarm 0x00 then matches current 0x12 (both hour 0), and alarm 0x92 (hour 12) does not match current 0x12.
- R8: `alarm_hit` rises in the cycle after the clock edge that samples `upd_stb` high with a match, and lasts exactly one cycle. It never rises without a strobe.
- R9: While `freeze` is 1, a strobe produces no pulse.
- R10: While `div_hold` is 1, a strobe produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | Seconds update strobe; current bytes already hold the new time |
| bin_mode | input | 1 | 1: binary data, 0: BCD data |
| hr24_mode | input | 1 | 1: 24-hour hours, 0: 12-hour hours with PM in bit 7 |
| freeze | input | 1 | Time frozen for setting; suppresses matches |
| div_hold | input | 1 | Dividers held in reset; suppresses matches |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
The match pulse comes out of one register. It is due in the cycle that follows the rising edge that samples the strobe, and it must have cleared one cycle later. The bench drives the strobe on a falling edge and samples `alarm_hit` on the next falling edge, half a cycle after the register loads. It drops the strobe and samples again one cycle later to confirm the pulse width. For scenarios in which the result must stay low, the bench holds matching bytes without a strobe for several cycles and confirms that `alarm_hit` stays low throughout.

// File: rtl/alarm_matcher.sv
module alarm_matcher (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_stb,
  input  logic       bin_mode,
  input  logic       hr24_mode,
  input  logic       freeze,
  input  logic       div_hold,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hr,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hr,
  output logic       alarm_hit
);

  localparam logic [1:0] WILD = 2'b11;

  function automatic logic [7:0] field_val(input logic [7:0] b, input logic bin);
    logic [7:0] hi, lo;
    hi = {4'd0, b[7:4]};
    lo = {4'd0, b[3:0]};
    return bin ? b : (hi * 8'd10 + lo);
  endfunction

  function automatic logic [7:0] hour_val(input logic [7:0] b, input logic bin, input logic h24);
    logic [7:0] base;
    if (h24) return field_val(b, bin);
    base = field_val({1'b0, b[6:0]}, bin) % 8'd12;
    return b[7] ? base + 8'd12 : base;
  endfunction

  logic sec_ok, min_ok, hr_ok, enable;

  assign sec_ok = (alm_sec[7:6] == WILD) ||
                  (field_val(alm_sec, bin_mode) == field_val(cur_sec, bin_mode));
  assign min_ok = (alm_min[7:6] == WILD) ||
                  (field_val(alm_min, bin_mode) == field_val(cur_min, bin_mode));
  assign hr_ok  = (alm_hr[7:6] == WILD) ||
                  (hour_val(alm_hr, bin_mode, hr24_mode) == hour_val(cur_hr, bin_mode, hr24_mode));
  assign enable = !freeze && !div_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) alarm_hit <= 1'b0;
    else        alarm_hit <= upd_stb && enable && sec_ok && min_ok && hr_ok;
  end

endmodule

// File: rtl/alarm_matcher_sva.sv
module alarm_matcher_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_stb,
  input logic       freeze,
  input logic       div_hold,
  input logic [7:0] alm_sec,
  input logic [7:0] alm_min,
  input logic [7:0] alm_hr,
  input logic [7:0] cur_sec,
  input logic [7:0] cur_min,
  input logic [7:0] cur_hr,
  input logic       alarm_hit
);

  assert_reset_low_R1: assert property (@(posedge clk) !rst_n |=> !alarm_hit);

  assert_same_bytes_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && !freeze && !div_hold && alm_sec == cur_sec && alm_min == cur_min &&
     alm_hr == cur_hr) |=> alarm_hit);

  assert_all_wild_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && !freeze && !div_hold && alm_sec[7:6] == 2'b11 &&
     alm_min[7:6] == 2'b11 && alm_hr[7:6] == 2'b11) |=> alarm_hit);

  assert_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |=> !alarm_hit);

  assert_freeze_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !alarm_hit);

  assert_hold_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |=> !alarm_hit);

endmodule

bind alarm_matcher alarm_matcher_sva u_sva (
  .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .freeze(freeze), .div_hold(div_hold),
  .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
  .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr), .alarm_hit(alarm_hit)
);

// File: tb/alarm_matcher_tb.sv
`timescale 1ns/1ps
module alarm_matcher_tb;
  logic clk = 1'b0, rst_n = 1'b0, upd_stb = 1'b0;
  logic bin_mode = 1'b0, hr24_mode = 1'b1, freeze = 1'b0, div_hold = 1'b0;
  logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hr = 8'h00;
  logic alarm_hit;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  alarm_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .bin_mode(bin_mode),
    .hr24_mode(hr24_mode), .freeze(freeze), .div_hold(div_hold),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr), .alarm_hit(alarm_hit)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: alarm_hit=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] as, am, ah, cs, cm, ch);
    alm_sec = as; alm_min = am; alm_hr = ah;
    cur_sec = cs; cur_min = cm; cur_hr = ch;
  endtask

  // one strobe; pulse due one cycle later, gone the cycle after
  task automatic strobe(input logic exp, input string tag);
    @(negedge clk) upd_stb = 1'b1;
    @(negedge clk) upd_stb = 1'b0;
    check(alarm_hit, exp, tag);
    @(negedge clk);
    check(alarm_hit, 1'b0, {tag, " R8 width"});
  endtask

  task automatic t_reset;
    check(alarm_hit, 1'b0, "R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    check(alarm_hit, 1'b0, "R1 after reset");
  endtask

  task automatic t_exact;
    bin_mode = 0; hr24_mode = 1;
    set_time(8'h30, 8'h45, 8'h13, 8'h30, 8'h45, 8'h13);
    strobe(1'b1, "R2 exact match");
    set_time(8'h59, 8'h59, 8'h23, 8'h59, 8'h59, 8'h23);
    strobe(1'b1, "R2 end of day");
  endtask

  task automatic t_mismatch;
    set_time(8'h30, 8'h45, 8'h13, 8'h31, 8'h45, 8'h13);
    strobe(1'b0, "R3 seconds differ");
    set_time(8'h30, 8'h45, 8'h13, 8'h30, 8'h44, 8'h13);
    strobe(1'b0, "R3 minutes differ");
    set_time(8'h30, 8'h45, 8'h13, 8'h30, 8'h45, 8'h14);
    strobe(1'b0, "R3 hours differ");
  endtask

  task automatic t_wild;
    set_time(8'hFF, 8'hC0, 8'hC7, 8'h12, 8'h34, 8'h05);
    strobe(1'b1, "R4 all wildcard a");
    set_time(8'hFF, 8'hC0, 8'hC7, 8'h59, 8'h00, 8'h22);
    strobe(1'b1, "R4 all wildcard b");
    set_time(8'hC3, 8'h10, 8'h08, 8'h47, 8'h10, 8'h08);
    strobe(1'b1, "R4 seconds wildcard");
    set_time(8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h17);
    strobe(1'b1, "R4 hours wildcard");
    set_time(8'hC0, 8'h00, 8'h10, 8'h05, 8'h01, 8'h10);
    strobe(1'b0, "R4 wildcard with other field off");
  endtask

  task automatic t_coding;
    bin_mode = 0;
    set_time(8'h0A, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00);
    strobe(1'b1, "R5 BCD value 10");
    bin_mode = 1;
    strobe(1'b0, "R6 binary 0x0A vs 0x10");
    set_time(8'h3B, 8'h3B, 8'h17, 8'h3B, 8'h3B, 8'h17);
    strobe(1'b1, "R6 binary match");
    bin_mode = 0;
  endtask

  task automatic t_12h;
    hr24_mode = 0; bin_mode = 0;
    set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h12);
    strobe(1'b1, "R7 12h 0x00 vs 0x12");
    set_time(8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h12);
    strobe(1'b0, "R7 12h PM12 vs AM12");
    set_time(8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h81);
    strobe(1'b1, "R7 12h 1PM");
    bin_mode = 1;
    set_time(8'h00, 8'h00, 8'h8C, 8'h00, 8'h00, 8'h80);
    strobe(1'b1, "R7 12h binary PM normalise");
    bin_mode = 0; hr24_mode = 1;
    set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h12);
    strobe(1'b0, "R7 24h 0x00 vs 0x12");
  endtask

  task automatic t_no_strobe;
    set_time(8'h11, 8'h22, 8'h03, 8'h11, 8'h22, 8'h03);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(alarm_hit, 1'b0, "R8 no strobe");
    end
  endtask

  task automatic t_gating;
    set_time(8'h11, 8'h22, 8'h03, 8'h11, 8'h22, 8'h03);
    freeze = 1;
    strobe(1'b0, "R9 frozen");
    freeze = 0; div_hold = 1;
    strobe(1'b0, "R10 dividers held");
    div_hold = 0;
    strobe(1'b1, "R10 released");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_exact;
    t_mismatch;
    t_wild;
    t_coding;
    t_12h;
    t_no_strobe;
    t_gating;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: finished=0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule